// File: doc/BRIEF.md
# Host Register Window with RAM Arbitration

This block sits between a host I/O bus and the internal side of a controller. The host sees a window of word-wide registers, selected by a small index. The block decodes each host cycle and sends it to one of three places. Low indices are plain registers held in flip-flops. Two write-only pointer registers (a base and an offset) set up an indirect port. All other indices, the indirect port and every attribute-space access resolve to a word in a shared internal RAM.

RAM-backed cycles go through a request/grant handshake with an external arbiter. The block holds the host wait line for the whole cycle, and every cycle inserts at least one wait state, even a flop-register cycle. This lets the host cycle line up with the internal clock. One host cycle is in flight at a time. A start pulse that arrives while a cycle is still running is dropped.

Register indices used below are for the default parameters: `NUM_REGS`=32, `NUM_HW`=8, `MM_BASE`=0, `ATTR_BASE`=0x400, `HW_WAITS`=1.

Top module: `hreg_window`

## Requirements
- R1: After reset, `host_wait`, `host_done`, `ram_req` and `ram_en` are low, `host_rdata` is 0, and every flop register (indices 0..7) reads 0.
- R2: An I/O cycle (`host_space`=0) to index 0..7 reads or writes a flop register with no RAM activity. It holds `host_wait` for exactly `HW_WAITS` cycles (1 by default). `host_done` is high for one cycle, in the first cycle where `host_wait` is low again.
- R3: Index 8 (pointer base) and index 9 (pointer offset) store the low 12 bits of a write. A read of either returns 0 and uses the same wait timing as R2, with no RAM activity.
- R4: An I/O cycle to index 11..31 accesses RAM word `MM_BASE` + index.
- R5: An attribute-space cycle (`host_space`=1) with offset `host_addr` accesses RAM word 0x400 + `host_addr`.
- R6: An I/O cycle to index 10 accesses RAM word (pointer base + pointer offset), taken modulo 2^12.
- R7: For a RAM-backed cycle, `ram_req` rises in the cycle after the start pulse. It stays high until the cycle in which `ram_gnt` is sampled high.
- R8: `ram_en` is high for exactly the one cycle after the grant. `host_wait` drops in the cycle after that. With a grant delay of d cycles, `host_wait` is high for d+2 cycles.
- R9: `host_wait` is high in every cycle that `ram_req` or `ram_en` is high. `host_wait` rises in the cycle after any accepted start pulse.
- R10: A write drives `ram_we`=1 and `ram_wdata` with the host data during `ram_en`. A read returns the `ram_rdata` seen during `ram_en` on `host_rdata`, and `host_rdata` keeps that value until the next read.
- R11: A `host_start` pulse that arrives while `host_wait` is high is ignored and has no effect on any register or RAM word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_start | input | 1 | One-cycle pulse that starts a host cycle |
| host_space | input | 1 | 0 = I/O register window, 1 = attribute space |
| host_addr | input | 10 | Register index (low 5 bits) or attribute offset |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Data from the most recent read |
| host_wait | output | 1 | Wait line; high while a cycle is in progress |
| host_done | output | 1 | One-cycle completion pulse |
| ram_req | output | 1 | Request to the RAM arbiter |
| ram_gnt | input | 1 | Grant from the RAM arbiter |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable (valid with ram_en) |
| ram_addr | output | 12 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, sampled while ram_en is high |

## Verification
A wrong decode shows up at the ports in the same cycle `ram_en` rises. The bench records every RAM address used and compares it with the address it expects for the index or offset. A sequencer stuck in the wrong state shows up within one cycle as a wrong wait length, a missing done pulse, or a request or enable seen on a flop-register cycle. Corrupted pointer or flop-register contents show up on the next read back or the next indirect RAM access. A start that should have been dropped is caught by reading back the target it would have written.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

   typedef enum logic [1:0] {
      TGT_FLOP   = 2'd0,
      TGT_PTRREG = 2'd1,
      TGT_RAM    = 2'd2
   } tgt_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HWWS  = 2'd1,
      ST_REQ   = 2'd2,
      ST_ACC   = 2'd3
   } seq_st_e;

endpackage

// File: rtl/hreg_decode.sv
module hreg_decode
   import hreg_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int RAM_AW    = 12,
   parameter int NUM_REGS  = 32,
   parameter int NUM_HW    = 8,
   parameter int MM_BASE   = 0,
   parameter int ATTR_BASE = 'h400,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              space,
   input  logic [ADDR_W-1:0] addr,
   input  logic [RAM_AW-1:0] ptr_base,
   input  logic [RAM_AW-1:0] ptr_ofs,
   output tgt_e              tgt,
   output logic [IDX_W-1:0]  idx,
   output logic [RAM_AW-1:0] ram_addr
);
   localparam int IDX_PBASE = NUM_HW;
   localparam int IDX_POFS  = NUM_HW + 1;
   localparam int IDX_PDATA = NUM_HW + 2;

   always_comb begin
      idx      = addr[IDX_W-1:0];
      tgt      = TGT_RAM;
      ram_addr = '0;
      if (space) begin
         ram_addr = RAM_AW'(ATTR_BASE) + RAM_AW'(addr);
      end else if (int'(idx) < NUM_HW) begin
         tgt = TGT_FLOP;
      end else if (int'(idx) == IDX_PBASE || int'(idx) == IDX_POFS) begin
         tgt = TGT_PTRREG;
      end else if (int'(idx) == IDX_PDATA) begin
         ram_addr = ptr_base + ptr_ofs;
      end else begin
         ram_addr = RAM_AW'(MM_BASE) + RAM_AW'(idx);
      end
   end
endmodule

// File: rtl/hreg_flopfile.sv
module hreg_flopfile #(
   parameter int DATA_W   = 16,
   parameter int RAM_AW   = 12,
   parameter int NUM_REGS = 32,
   parameter int NUM_HW   = 8,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic [RAM_AW-1:0] ptr_base,
   output logic [RAM_AW-1:0] ptr_ofs
);
   localparam int IDX_PBASE = NUM_HW;
   localparam int IDX_POFS  = NUM_HW + 1;

   logic [DATA_W-1:0] regs [NUM_HW];

   for (genvar g = 0; g < NUM_HW; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              regs[g] <= '0;
         else if (wr_en && idx == IDX_W'(g))      regs[g] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_base <= '0;
         ptr_ofs  <= '0;
      end else if (wr_en) begin
         if (int'(idx) == IDX_PBASE) ptr_base <= wdata[RAM_AW-1:0];
         if (int'(idx) == IDX_POFS)  ptr_ofs  <= wdata[RAM_AW-1:0];
      end
   end

   // pointer registers are write-only: their indices fall through to zero
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_HW; i++)
         if (idx == IDX_W'(i)) rd_data = regs[i];
   end
endmodule

// File: rtl/hreg_seq.sv
module hreg_seq
   import hreg_pkg::*;
#(
   parameter int HW_WAITS = 1,
   localparam int WC_W    = (HW_WAITS > 1) ? $clog2(HW_WAITS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_start,
   input  tgt_e tgt_live,
   input  logic ram_gnt,
   output logic accept,
   output logic flop_fire,
   output logic ram_fire,
   output logic host_wait,
   output logic host_done,
   output logic ram_req,
   output logic ram_en
);
   seq_st_e          st;
   logic [WC_W-1:0]  wcnt;

   assign accept    = host_start && (st == ST_IDLE);
   assign flop_fire = (st == ST_HWWS) && (wcnt == '0);
   assign ram_fire  = (st == ST_ACC);
   assign host_wait = (st != ST_IDLE);
   assign ram_req   = (st == ST_REQ);
   assign ram_en    = (st == ST_ACC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         wcnt      <= '0;
         host_done <= 1'b0;
      end else begin
         host_done <= 1'b0;
         unique case (st)
            ST_IDLE: if (host_start) begin
               if (tgt_live == TGT_RAM) st <= ST_REQ;
               else begin
                  st   <= ST_HWWS;
                  wcnt <= WC_W'(HW_WAITS - 1);
               end
            end
            ST_HWWS: if (wcnt == '0) begin
               st        <= ST_IDLE;
               host_done <= 1'b1;
            end else begin
               wcnt <= wcnt - 1'b1;
            end
            ST_REQ: if (ram_gnt) st <= ST_ACC;
            ST_ACC: begin
               st        <= ST_IDLE;
               host_done <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R7: an unanswered request is held
   a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      ram_req && !ram_gnt |=> ram_req);
   // R8: the access strobe follows a grant by one cycle and drops the request
   a_r8_en_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      ram_req && ram_gnt |=> ram_en && !ram_req);
   // R8: wait released the cycle after the access
   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en |=> !host_wait && host_done);
   // R9: wait covers all RAM activity
   a_r9_wait_covers: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_req || ram_en) |-> host_wait);
   // R9: an accepted start always inserts a wait state
   a_r9_min_wait: assert property (@(posedge clk) disable iff (!rst_n)
      host_start && !host_wait |=> host_wait);
   // R8: request and strobe never overlap
   a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_req, ram_en}));
   // R2: done is a single-cycle pulse
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |=> !host_done);
endmodule

// File: rtl/hreg_window.sv
module hreg_window
   import hreg_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 10,
   parameter int RAM_AW    = 12,
   parameter int NUM_REGS  = 32,
   parameter int NUM_HW    = 8,
   parameter int MM_BASE   = 0,
   parameter int ATTR_BASE = 'h400,
   parameter int HW_WAITS  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_start,
   input  logic              host_space,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_we,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_wait,
   output logic              host_done,
   output logic              ram_req,
   input  logic              ram_gnt,
   output logic              ram_en,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata
);
   localparam int IDX_W = $clog2(NUM_REGS);

   if (HW_WAITS < 1)              begin : g_bad_ws   $error("HW_WAITS must be at least 1"); end
   if (NUM_HW + 3 > NUM_REGS)     begin : g_bad_map  $error("register window too small");   end
   if (RAM_AW > DATA_W)           begin : g_bad_aw   $error("pointer wider than data");     end
   if (IDX_W > ADDR_W)            begin : g_bad_addr $error("address narrower than index"); end
   if ((1 << IDX_W) != NUM_REGS)  begin : g_bad_pow  $error("NUM_REGS must be a power of 2"); end

   tgt_e              tgt_live;
   logic [IDX_W-1:0]  idx_live;
   logic [RAM_AW-1:0] raddr_live;
   logic [RAM_AW-1:0] ptr_base, ptr_ofs;
   logic [IDX_W-1:0]  idx_q;
   logic [RAM_AW-1:0] raddr_q;
   logic              we_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] flop_rd;
   logic              accept, flop_fire, ram_fire;

   hreg_decode #(
      .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .NUM_REGS(NUM_REGS), .NUM_HW(NUM_HW),
      .MM_BASE(MM_BASE), .ATTR_BASE(ATTR_BASE)
   ) u_dec (
      .space(host_space), .addr(host_addr), .ptr_base(ptr_base), .ptr_ofs(ptr_ofs),
      .tgt(tgt_live), .idx(idx_live), .ram_addr(raddr_live)
   );

   hreg_seq #(.HW_WAITS(HW_WAITS)) u_seq (
      .clk(clk), .rst_n(rst_n), .host_start(host_start), .tgt_live(tgt_live),
      .ram_gnt(ram_gnt), .accept(accept), .flop_fire(flop_fire), .ram_fire(ram_fire),
      .host_wait(host_wait), .host_done(host_done), .ram_req(ram_req), .ram_en(ram_en)
   );

   hreg_flopfile #(
      .DATA_W(DATA_W), .RAM_AW(RAM_AW), .NUM_REGS(NUM_REGS), .NUM_HW(NUM_HW)
   ) u_ff (
      .clk(clk), .rst_n(rst_n), .wr_en(flop_fire && we_q), .idx(idx_q),
      .wdata(wdata_q), .rd_data(flop_rd), .ptr_base(ptr_base), .ptr_ofs(ptr_ofs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         raddr_q <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
      end else if (accept) begin
         idx_q   <= idx_live;
         raddr_q <= raddr_live;
         we_q    <= host_we;
         wdata_q <= host_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    host_rdata <= '0;
      else if (flop_fire && !we_q)   host_rdata <= flop_rd;
      else if (ram_fire && !we_q)    host_rdata <= ram_rdata;
   end

   assign ram_we    = ram_en && we_q;
   assign ram_addr  = raddr_q;
   assign ram_wdata = wdata_q;

   // R10: write strobe only during an access
   a_r10_we_in_en: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ram_en);
   // R10: address and data stay put from request through access
   a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ram_req |=> $stable(ram_addr) && $stable(ram_wdata));
   // R11: latched request fields do not move while busy
   a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      host_wait && !host_done |=> $stable(raddr_q) || !host_wait);
endmodule

// File: tb/hreg_window_bench.sv
module hreg_window_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_start = 1'b0, host_space = 1'b0, host_we = 1'b0;
   logic [9:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        host_wait, host_done, ram_req, ram_gnt, ram_en, ram_we;
   logic [11:0] ram_addr;
   logic [15:0] ram_wdata, ram_rdata;

   int n_chk = 0, n_bad = 0;
   int gnt_delay = 0;
   int req_cnt = 0;
   int en_count = 0;
   logic [11:0] last_addr = '0;
   logic [15:0] mem [4096];

   always #2 clk = ~clk;

   hreg_window u_hreg_window (
      .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_space(host_space),
      .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_wait(host_wait), .host_done(host_done),
      .ram_req(ram_req), .ram_gnt(ram_gnt), .ram_en(ram_en), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   // arbiter and RAM model
   assign ram_gnt   = ram_req && (req_cnt >= gnt_delay);
   assign ram_rdata = mem[ram_addr];
   always @(posedge clk) begin
      req_cnt <= ram_req ? req_cnt + 1 : 0;
      if (ram_en) begin
         en_count  <= en_count + 1;
         last_addr <= ram_addr;
         if (ram_we) mem[ram_addr] <= ram_wdata;
      end
   end

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic host_cycle(input logic sp, input logic [9:0] a, input logic we,
                             input logic [15:0] wd, output logic [15:0] rd,
                             output int waits, output int reqs, output logic dn);
      @(negedge clk);
      host_start = 1'b1; host_space = sp; host_addr = a; host_we = we; host_wdata = wd;
      @(negedge clk);
      host_start = 1'b0;
      waits = 0; reqs = 0;
      while (host_wait && waits < 1000) begin
         waits++;
         if (ram_req) reqs++;
         @(negedge clk);
      end
      dn = host_done;
      rd = host_rdata;
   endtask

   task automatic t_reset();
      logic [15:0] rd; int w, r; logic dn;
      check("R1 wait", int'(host_wait), 0);
      check("R1 done", int'(host_done), 0);
      check("R1 req", int'(ram_req), 0);
      check("R1 en", int'(ram_en), 0);
      check("R1 rdata", int'(host_rdata), 0);
      for (int i = 0; i < 8; i++) begin
         host_cycle(1'b0, 10'(i), 1'b0, 16'h0, rd, w, r, dn);
         check("R1 flop reg", int'(rd), 0);
      end
   endtask

   task automatic t_flop();
      logic [15:0] rd; int w, r; logic dn; int e0;
      e0 = en_count;
      host_cycle(1'b0, 10'd3, 1'b1, 16'hA5A5, rd, w, r, dn);
      check("R2 write waits", w, 1);
      check("R2 done", int'(dn), 1);
      host_cycle(1'b0, 10'd7, 1'b1, 16'h0F0F, rd, w, r, dn);
      host_cycle(1'b0, 10'd3, 1'b0, 16'h0, rd, w, r, dn);
      check("R2 read reg3", int'(rd), 'hA5A5);
      check("R2 read waits", w, 1);
      host_cycle(1'b0, 10'd7, 1'b0, 16'h0, rd, w, r, dn);
      check("R2 read reg7", int'(rd), 'h0F0F);
      check("R2 no RAM access", en_count - e0, 0);
   endtask

   task automatic t_ptrregs();
      logic [15:0] rd; int w, r; logic dn; int e0;
      e0 = en_count;
      host_cycle(1'b0, 10'd8, 1'b1, 16'hF120, rd, w, r, dn);
      host_cycle(1'b0, 10'd9, 1'b1, 16'h0005, rd, w, r, dn);
      host_cycle(1'b0, 10'd8, 1'b0, 16'h0, rd, w, r, dn);
      check("R3 base reads zero", int'(rd), 0);
      check("R3 waits", w, 1);
      host_cycle(1'b0, 10'd3, 1'b0, 16'h0, rd, w, r, dn);
      host_cycle(1'b0, 10'd9, 1'b0, 16'h0, rd, w, r, dn);
      check("R3 offset reads zero", int'(rd), 0);
      check("R3 no RAM access", en_count - e0, 0);
   endtask

   task automatic t_ptrdata();
      logic [15:0] rd; int w, r; logic dn;
      host_cycle(1'b0, 10'd10, 1'b1, 16'h1234, rd, w, r, dn);
      check("R6 addr", int'(last_addr), 'h125);
      check("R6 word", int'(mem[12'h125]), 'h1234);
      check("R8 waits d0", w, 2);
      host_cycle(1'b0, 10'd8, 1'b1, 16'h0FFE, rd, w, r, dn);
      host_cycle(1'b0, 10'd9, 1'b1, 16'h0003, rd, w, r, dn);
      mem[12'h001] = 16'h5150;
      host_cycle(1'b0, 10'd10, 1'b0, 16'h0, rd, w, r, dn);
      check("R6 wrap addr", int'(last_addr), 'h001);
      check("R10 read data", int'(rd), 'h5150);
   endtask

   task automatic t_mm();
      logic [15:0] rd; int w, r; logic dn;
      host_cycle(1'b0, 10'd20, 1'b1, 16'hBEEF, rd, w, r, dn);
      check("R4 addr idx20", int'(last_addr), 20);
      check("R10 write data", int'(mem[20]), 'hBEEF);
      check("R8 done", int'(dn), 1);
      mem[31] = 16'h7777;
      host_cycle(1'b0, 10'd31, 1'b0, 16'h0, rd, w, r, dn);
      check("R4 addr idx31", int'(last_addr), 31);
      check("R4 read idx31", int'(rd), 'h7777);
      host_cycle(1'b0, 10'd11, 1'b0, 16'h0, rd, w, r, dn);
      check("R4 addr idx11", int'(last_addr), 11);
      host_cycle(1'b0, 10'd3, 1'b1, 16'h1111, rd, w, r, dn);
      check("R10 rdata held", int'(rd), int'(mem[11]));
   endtask

   task automatic t_attr();
      logic [15:0] rd; int w, r; logic dn;
      mem[12'h407] = 16'hC0DE;
      host_cycle(1'b1, 10'h007, 1'b0, 16'h0, rd, w, r, dn);
      check("R5 addr", int'(last_addr), 'h407);
      check("R5 read", int'(rd), 'hC0DE);
      host_cycle(1'b1, 10'h3FF, 1'b1, 16'h4242, rd, w, r, dn);
      check("R5 top addr", int'(last_addr), 'h7FF);
      check("R5 write", int'(mem[12'h7FF]), 'h4242);
   endtask

   task automatic t_gnt_delay();
      logic [15:0] rd; int w, r; logic dn;
      for (int d = 1; d <= 4; d += 3) begin
         gnt_delay = d;
         host_cycle(1'b0, 10'd25, 1'b1, 16'(16'h900 + d), rd, w, r, dn);
         check("R8 waits with delay", w, d + 2);
         check("R7 request cycles", r, d + 1);
         check("R10 delayed write", int'(mem[25]), 'h900 + d);
      end
      gnt_delay = 0;
   endtask

   task automatic t_busy_ignore();
      logic [15:0] rd; int w, r; logic dn;
      host_cycle(1'b0, 10'd2, 1'b1, 16'h2222, rd, w, r, dn);
      gnt_delay = 3;
      @(negedge clk);
      host_start = 1'b1; host_space = 1'b0; host_addr = 10'd14; host_we = 1'b1; host_wdata = 16'h1414;
      @(negedge clk);
      host_addr = 10'd2; host_wdata = 16'h0BAD;
      @(negedge clk);
      host_start = 1'b0;
      w = 0;
      while (host_wait && w < 1000) begin w++; @(negedge clk); end
      gnt_delay = 0;
      check("R11 first cycle landed", int'(mem[14]), 'h1414);
      check("R11 no trailing cycle", int'(host_wait), 0);
      host_cycle(1'b0, 10'd2, 1'b0, 16'h0, rd, w, r, dn);
      check("R11 reg2 untouched", int'(rd), 'h2222);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 16'(i ^ 16'h3C00);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_flop();
      t_ptrregs();
      t_ptrdata();
      t_mm();
      t_attr();
      t_gnt_delay();
      t_busy_ignore();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule